// File: doc/BRIEF.md
# Multi-drive attention summary register

This block holds one attention flag for each of a set of disk drives (eight by default) and shows them together as a single summary word. A drive raises its flag with a one-cycle set pulse when it has something to report, such as a finished seek or an error. The host reads every flag at once. It clears any chosen group of flags with one write, where each 1 in the write mask clears the flag of that drive. A drive-clear command aimed at one drive drops that drive's flag and leaves the others alone. An interrupt request stays high while any flag is up.

The summary word is built from the per-drive flags every cycle and is not stored as a separate copy. A host write or read goes through whatever state the drive selected for the access is in: a busy drive does not refuse the write, and a drive with no medium loaded does not blank the read. The read strobe loads the summary into a read-data register, which keeps that value until the next strobe. The asynchronous reset is released in step with the clock.

Top module: `attn_summary_reg`

## Requirements
- R1: While reset is applied, and after it is released, all flags are 0, so `summary` is 0, `irq` is 0 and `rd_data` is 0.
- R2: A 1 on `attn_set[i]` at a clock edge sets `summary[i]` from that edge on. The flag stays set until something clears it.
- R3: When `wr_en` is 1 at an edge, every bit i with `wr_mask[i]`=1 clears `summary[i]`. Bits with `wr_mask[i]`=0 keep their value.
- R4: A 1 on `drive_clr[i]` at an edge clears `summary[i]` only. Every other bit keeps its value.
- R5: If `attn_set[i]` and a clear (from a mask bit or `drive_clr[i]`) reach drive i at the same edge, the flag ends up set.
- R6: `irq` is 1 exactly when at least one bit of `summary` is 1.
- R7: A 1 on `rd_en` at an edge loads into `rd_data` the `summary` value that was present just before that edge. With `rd_en` at 0, `rd_data` holds its value.
- R8: `drv_busy` does not affect how host writes are accepted, and `drv_online` does not affect reads. A write still clears flags when every drive is busy, and a read still returns the flags when no drive is online.
- R9: When `wr_en` is 0, `wr_mask` has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| attn_set | input | 8 | Per-drive attention set pulses |
| drive_clr | input | 8 | Per-drive drive-clear command pulses |
| wr_en | input | 1 | Host write strobe for the summary |
| wr_mask | input | 8 | Host write data; 1 clears that drive's flag |
| rd_en | input | 1 | Host read strobe |
| drv_busy | input | 8 | Per-drive command-in-progress status (no effect on writes) |
| drv_online | input | 8 | Per-drive medium-present status (no effect on reads) |
| summary | output | 8 | Current flags, bit i for drive i |
| rd_data | output | 8 | Summary value captured by the last read strobe |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The hardest situation to create from the ports is a set and a clear landing on the same drive in the same cycle while other drives are being cleared by that same mask. The stimulus table builds up a mixed flag pattern first. It then issues a masked write whose mask covers a drive being set in that cycle, and a drive-clear paired with a set on one drive, so that the expected word shows both the set winning and its neighbours being cleared. Writes go out with every drive marked busy, and reads go out with no drive online, to show that both conditions are ignored.

// File: rtl/attn_pkg.sv
package attn_pkg;

  localparam int RST_SYNC_DEPTH = 2;

  // Priority rule for one flag: a new event beats any clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    logic nxt;
    nxt = cur;
    if (clr) nxt = 1'b0;
    if (set) nxt = 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/attn_rst_sync.sv
module attn_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[DEPTH-1];

endmodule

// File: rtl/attn_clear_decode.sv
module attn_clear_decode #(
  parameter int NUM_DRV = 8
) (
  input  logic               wr_en,
  input  logic [NUM_DRV-1:0] wr_mask,
  input  logic [NUM_DRV-1:0] drive_clr,
  output logic [NUM_DRV-1:0] clr_vec
);

  logic [NUM_DRV-1:0] host_clr;

  // Host write is not qualified by drive busy state on purpose.
  always_comb begin
    host_clr = wr_en ? wr_mask : '0;
    clr_vec  = host_clr | drive_clr;
  end

endmodule

// File: rtl/attn_flag_cell.sv
module attn_flag_cell
  import attn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = flag_next(flag_q, set_i, clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/attn_read_port.sv
module attn_read_port #(
  parameter int NUM_DRV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [NUM_DRV-1:0] flags,
  output logic [NUM_DRV-1:0] rd_data
);

  logic [NUM_DRV-1:0] rd_q;
  logic [NUM_DRV-1:0] rd_d;

  always_comb begin
    rd_d = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/attn_summary_reg.sv
module attn_summary_reg
  import attn_pkg::*;
#(
  parameter int NUM_DRV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DRV-1:0] attn_set,
  input  logic [NUM_DRV-1:0] drive_clr,
  input  logic               wr_en,
  input  logic [NUM_DRV-1:0] wr_mask,
  input  logic               rd_en,
  input  logic [NUM_DRV-1:0] drv_busy,
  input  logic [NUM_DRV-1:0] drv_online,
  output logic [NUM_DRV-1:0] summary,
  output logic [NUM_DRV-1:0] rd_data,
  output logic               irq
);

  logic               rst_n_int;
  logic [NUM_DRV-1:0] clr_vec;
  logic [NUM_DRV-1:0] flag_vec;
  logic               unused_status;

  // Drive status is carried to the boundary but gates no host access.
  assign unused_status = ^{drv_busy, drv_online};

  attn_rst_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  attn_clear_decode #(.NUM_DRV(NUM_DRV)) u_dec (
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .drive_clr (drive_clr),
    .clr_vec   (clr_vec)
  );

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    attn_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .set_i  (attn_set[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_vec[g])
    );
  end

  attn_read_port #(.NUM_DRV(NUM_DRV)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rd_en   (rd_en),
    .flags   (flag_vec),
    .rd_data (rd_data)
  );

  assign summary = flag_vec;
  assign irq     = |flag_vec;

endmodule

// File: rtl/attn_summary_chk.sv
module attn_summary_chk #(
  parameter int NUM_DRV = 8
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [NUM_DRV-1:0] attn_set,
  input logic [NUM_DRV-1:0] drive_clr,
  input logic               wr_en,
  input logic [NUM_DRV-1:0] wr_mask,
  input logic               rd_en,
  input logic [NUM_DRV-1:0] summary,
  input logic [NUM_DRV-1:0] rd_data,
  input logic               irq
);

  p_reset_r1: assert property (@(posedge clk) !rst_ok |-> (summary == '0 && rd_data == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((summary & $past(attn_set)) == $past(attn_set)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_en |=> ((summary & $past(wr_mask & ~attn_set)) == '0));

  p_dclr_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (drive_clr != '0) |=> ((summary & $past(drive_clr & ~attn_set)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((summary & ~$past(attn_set | drive_clr | (wr_en ? wr_mask : '0)))
              == ($past(summary) & ~$past(attn_set | drive_clr | (wr_en ? wr_mask : '0)))));

  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(irq) |-> ($past(attn_set) != '0));

  p_read_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_en |=> (rd_data == $past(summary)));

  p_rdhold_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_en |=> $stable(rd_data));

endmodule

bind attn_summary_reg attn_summary_chk #(.NUM_DRV(NUM_DRV)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_int),
  .attn_set  (attn_set),
  .drive_clr (drive_clr),
  .wr_en     (wr_en),
  .wr_mask   (wr_mask),
  .rd_en     (rd_en),
  .summary   (summary),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/sim_attn_summary_reg.sv
module sim_attn_summary_reg;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int WATCHDOG = 5000;

  // {set, clr, wr_en(8b, bit0), mask, busy, online, expected}
  localparam logic [55:0] VEC [NV] = '{
    {8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h81},
    {8'h3C, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hBD},
    {8'h00, 8'h00, 8'h01, 8'h05, 8'hFF, 8'hFF, 8'hB8},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hB8},
    {8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hB0},
    {8'h02, 8'h02, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hB2},
    {8'h10, 8'h00, 8'h01, 8'hF0, 8'hFF, 8'hFF, 8'h12},
    {8'h00, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'h00, 8'h00}
  };

  logic       clk;
  logic       rst_n;
  logic [7:0] attn_set, drive_clr, wr_mask, drv_busy, drv_online;
  logic       wr_en, rd_en;
  logic [7:0] summary, rd_data;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  attn_summary_reg u0 (
    .clk(clk), .rst_n(rst_n), .attn_set(attn_set), .drive_clr(drive_clr),
    .wr_en(wr_en), .wr_mask(wr_mask), .rd_en(rd_en), .drv_busy(drv_busy),
    .drv_online(drv_online), .summary(summary), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    attn_set = '0; drive_clr = '0; wr_en = 1'b0; wr_mask = '0;
    rd_en = 1'b0; drv_busy = '0; drv_online = 8'hFF;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #1;
    repeat (2) @(negedge clk);
    // R1: state while reset held
    check8("R1 summary in reset", summary, 8'h00);
    check8("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) step();
    check8("R1 summary after release", summary, 8'h00);
    check8("R1 rd_data after release", rd_data, 8'h00);

    // Table walk: R2 R3 R4 R5 R8 R9, irq per R6
    for (int k = 0; k < NV; k++) begin
      attn_set   = VEC[k][55:48];
      drive_clr  = VEC[k][47:40];
      wr_en      = VEC[k][32];
      wr_mask    = VEC[k][31:24];
      drv_busy   = VEC[k][23:16];
      drv_online = VEC[k][15:8];
      step();
      idle();
      check8($sformatf("R2/R3/R4/R5/R8/R9 vector %0d", k), summary, VEC[k][7:0]);
      check8($sformatf("R6 irq vector %0d", k), {7'b0, irq}, {7'b0, VEC[k][7:0] != 8'h00});
    end

    // R7: read captures pre-edge value while a set lands on the same edge
    attn_set = 8'h44; step(); idle();
    attn_set = 8'h01; rd_en = 1'b1; drv_online = 8'h00; step(); idle();
    check8("R7 R8 read with no drive online", rd_data, 8'h44);
    check8("R2 set alongside read", summary, 8'h45);
    step();
    check8("R7 rd_data holds without strobe", rd_data, 8'h44);
    rd_en = 1'b1; step(); idle();
    check8("R7 second read", rd_data, 8'h45);

    // R5: set wins against drive clear and masked write together
    attn_set = 8'h80; drive_clr = 8'h80; wr_en = 1'b1; wr_mask = 8'h81; step(); idle();
    check8("R5 set beats both clears", summary, 8'hC4);

    // R4: single drive clear touches only its own bit
    drive_clr = 8'h04; step(); idle();
    check8("R4 drive clear isolated", summary, 8'hC0);

    // R1: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check8("R1 async reset clears", summary, 8'h00);
    check8("R1 async reset rd_data", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    check8("R6 irq low after reset", {7'b0, irq}, 8'h00);

    finish_run();
  end

endmodule